// File: doc/BRIEF.md
# Iterative Half-Adder Recursive Adder

This block adds two unsigned words with a latency that depends on the operands. Every bit position has one half adder, fed through a two-input multiplexer. When a request arrives, the multiplexers pass the external operands. The half-adder row produces a partial sum and a vector of carries, and both are captured in registers. On each later clock the multiplexers switch to the registered values. Each bit then half-adds its own previous sum to the carry that its lower neighbour produced, so every bit either absorbs an incoming carry or passes it up one position. All bits work in parallel in the same cycle. A completion detector watches the carries that are still travelling. When all of them are zero, the registered sum is the result.

A four-phase request/acknowledge handshake frames each addition. The requester raises the request with the operands applied. The block raises the acknowledge once the result has settled and holds the result while the request stays high. The requester then drops the request, the block drops the acknowledge, and it is ready for the next operation. Carries that leave the top bit in any pass are OR-collected into a registered carry-out, so the word together with the carry-out holds the full sum.

Top module: `recursive_adder`

## Requirements
- R1: While rst_ni is low, and after it is released with no request seen, ack_o, sum_o and cout_o are all zero.
- R2: A request sampled high in the idle state loads the operands. If the operands share no set bit (a & b == 0), ack_o is high after the second rising edge counted from the loading edge, with sum_o = a | b and cout_o = 0.
- R3: When ack_o is high, {cout_o, sum_o} equals a + b, taken to WIDTH+1 bits.
- R4: Let s = a ^ b and c = a & b, where c[i] is the carry leaving bit i. While c[WIDTH-2:0] is not zero, one feedback pass runs: with ci = (c << 1) truncated to WIDTH bits, c becomes s & ci and s becomes s ^ ci. If m passes are needed, ack_o rises after edge 1 + m counted from the loading edge, and at no time does any bit hold a set sum and a set pending carry together.
- R5: The number of feedback passes m never exceeds WIDTH-1. Adding 1 to the all-ones word reaches exactly WIDTH-1 passes and yields sum_o = 0 and cout_o = 1.
- R6: While ack_o is high and req_i stays high, ack_o, sum_o and cout_o hold their values, even if a_i and b_i change.
- R7: After req_i falls while ack_o is high, ack_o is low following the next rising edge, and the block returns to idle ready for a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request; high starts an addition, low completes the handshake |
| a_i | input | WIDTH | First operand, sampled on the loading edge |
| b_i | input | WIDTH | Second operand, sampled on the loading edge |
| ack_o | output | 1 | Acknowledge; high while the result is valid |
| sum_o | output | WIDTH | Sum word |
| cout_o | output | 1 | Carry-out of the top bit, accumulated over all passes |

## Verification
The acknowledge is due 1 + m rising edges after the edge that loads the operands, where the bench derives m itself from the pass recursion of R4. The bench drives and samples on falling edges, so the k-th falling edge after the operands are applied follows the loading edge plus k-1 further edges. It therefore expects ack_o at exactly falling edge m + 2 and reports both an early and a late acknowledge. After the request is released, ack_o must be low at the very next falling edge. The result hold is checked two edges after the operands have been corrupted, which is after the registers would have moved had they not been frozen.

// File: rtl/hra_pkg.sv
package hra_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } hra_state_e;
endpackage

// File: rtl/hra_ha_row.sv
// Row of operand/feedback muxes, each followed by a half adder.
module hra_ha_row #(
  parameter int WIDTH = 32
) (
  input  logic             sel_i,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic [WIDTH-1:0] fb_sum_i,
  input  logic [WIDTH-2:0] fb_cry_i,   // fb_cry_i[k]: carry leaving bit k
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] cry_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic x, y;
    if (i == 0) begin : g_lsb
      // nothing ever feeds bit 0 during feedback passes
      assign y = sel_i ? 1'b0 : op_b_i[i];
    end else begin : g_upper
      assign y = sel_i ? fb_cry_i[i-1] : op_b_i[i];
    end
    assign x        = sel_i ? fb_sum_i[i] : op_a_i[i];
    assign sum_o[i] = x ^ y;
    assign cry_o[i] = x & y;
  end
endmodule

// File: rtl/hra_done_det.sv
// Completion detection: no carry still heading into a bit of the word.
module hra_done_det #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-2:0] cry_i,
  output logic             settled_o
);
  assign settled_o = ~|cry_i;
endmodule

// File: rtl/hra_ctrl.sv
module hra_ctrl
  import hra_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic settled_i,
  output logic sel_o,
  output logic step_o,
  output logic ack_o
);
  localparam int CNT_W = $clog2(WIDTH + 1);

  hra_state_e state_q, state_d;
  logic [CNT_W-1:0] pass_q;

  always_comb begin
    state_d = state_q;
    step_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d = ST_RUN;
        step_o  = 1'b1;
      end
      ST_RUN: if (settled_i) state_d = ST_DONE;
              else           step_o  = 1'b1;
      ST_DONE: if (!req_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign sel_o = (state_q != ST_IDLE);
  assign ack_o = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pass_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE)   pass_q <= '0;
      else if (step_o)          pass_q <= pass_q + 1'b1;
    end
  end

  // feedback passes per operation are bounded by the word width
  assert_pass_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pass_q) <= WIDTH - 1);

  assert_ack_needs_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(req_i));
endmodule

// File: rtl/recursive_adder.sv
module recursive_adder #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             ack_o,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic             sel, step, settled;
  logic [WIDTH-1:0] row_sum, row_cry;
  logic [WIDTH-1:0] sum_q;
  logic [WIDTH-2:0] cry_q;   // carries headed into bits 1..WIDTH-1
  logic             cout_q;

  hra_ha_row #(.WIDTH(WIDTH)) u_row (
    .sel_i   (sel),
    .op_a_i  (a_i),
    .op_b_i  (b_i),
    .fb_sum_i(sum_q),
    .fb_cry_i(cry_q),
    .sum_o   (row_sum),
    .cry_o   (row_cry)
  );

  hra_done_det #(.WIDTH(WIDTH)) u_det (
    .cry_i    (cry_q),
    .settled_o(settled)
  );

  hra_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .settled_i(settled),
    .sel_o    (sel),
    .step_o   (step),
    .ack_o    (ack_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      cry_q  <= '0;
      cout_q <= 1'b0;
    end else if (step) begin
      sum_q  <= row_sum;
      cry_q  <= row_cry[WIDTH-2:0];
      // top carry leaves the word; collect it so overflow survives
      cout_q <= sel ? (cout_q | row_cry[WIDTH-1]) : row_cry[WIDTH-1];
    end
  end

  assign sum_o  = sum_q;
  assign cout_o = cout_q;

  assert_no_sum_and_carry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_q[WIDTH-2:0] & cry_q) == '0);

  assert_ack_when_settled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> cry_q == '0);

  assert_hold_result_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && $past(ack_o)) |-> ($stable(sum_o) && $stable(cout_o)));

  assert_ack_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_o) |-> !$past(req_i));

  assert_cout_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sel) && sel && $past(cout_o)) |-> cout_o);
endmodule

// File: tb/recursive_adder_bench.sv
module recursive_adder_bench;
  localparam int W    = 6;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         ack;
  logic [W-1:0] sum;
  logic         cout;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  recursive_adder #(.WIDTH(W)) u_recursive_adder (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .a_i(a), .b_i(b),
    .ack_o(ack), .sum_o(sum), .cout_o(cout)
  );

  task automatic check(input string req_tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req_tag, what, act, exp);
    end
  endtask

  // pass count per the recursion stated in R4
  function automatic int passes(input int x, input int y);
    int s = (x ^ y) & MASK;
    int c = (x & y) & MASK;
    int n = 0;
    while ((c & ((1 << (W - 1)) - 1)) != 0) begin
      int ci = (c << 1) & MASK;
      c = s & ci;
      s = s ^ ci;
      n++;
    end
    return n;
  endfunction

  task automatic run_op(input int x, input int y);
    int m   = passes(x, y);
    int exp = x + y;
    int cyc = 0;
    a = W'(x); b = W'(y); req = 1'b1;
    do begin
      @(negedge clk);
      cyc++;
    end while (!ack && cyc < 4 * W);
    check("R4", cyc, m + 2, "ack latency");
    check("R5", (m <= W - 1) ? 1 : 0, 1, "pass bound");
    check("R3", {cout, sum}, exp, "sum");
    if ((x & y) == 0) check("R2", {cout, sum}, x | y, "carry-free result");
    // corrupt operands, result must hold
    a = ~a; b = ~b;
    @(negedge clk); @(negedge clk);
    check("R6", ack, 1, "ack held");
    check("R6", {cout, sum}, exp, "result held");
    req = 1'b0;
    @(negedge clk);
    check("R7", ack, 0, "ack release");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1", {ack, cout, sum}, 0, "in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {ack, cout, sum}, 0, "after reset");

    // R5 worst case: all ones plus one
    check("R5", passes(MASK, 1), W - 1, "worst case pass count");
    run_op(MASK, 1);
    check("R5", {cout, sum}, 1 << W, "all-ones plus one");

    // R2 single carry-free case
    run_op(6'b101010, 6'b010101);

    // exhaustive sweep
    for (int x = 0; x <= MASK; x++)
      for (int y = 0; y <= MASK; y++)
        run_op(x, y);

    // R7: back-to-back request right after release is accepted
    run_op(3, 5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule